// File: doc/BRIEF.md
# Full-Search SAD Motion Estimator

This block finds the integer-pixel motion vector of one current block by comparing it against every candidate position of a square search window in a reference frame. A one-cycle `start` pulse carries the block's top-left coordinates. The block first fetches the current block once from the current-frame memory into a local register array. It then streams reference pixels only, candidate after candidate, and for each one it accumulates the sum of absolute differences against the stored block.

A running comparator keeps the lowest score. After the last candidate the block pulses `done` and presents the motion vector and the minimum SAD. The motion vector is the best candidate position minus the current position. Both frame memories are outside the block. Each is reached through a synchronous read port: the address is presented in one cycle and the data is returned in the next. A pixel at column x and row y lives at address y*FRM_W + x.

Window positions that would place any part of a candidate outside the reference frame are dropped from the window and never read. Block size, search range, pixel width and frame size are parameters.

Top module: `me_fullsearch`

## Requirements
- R1: With the block idle, a `start` pulse latches `start_x`/`start_y` and raises `busy` in the next cycle. `busy` stays high until the cycle in which `done` is high, where it is low again.
- R2: Each search reads the current frame exactly BLK*BLK times, in raster order within the block. All of these reads come before the first reference read, and none follows it.
- R3: Every candidate with column in [x-RANGE, x+RANGE] and row in [y-RANGE, y+RANGE] that fits the frame is scored. The reference read count per search is therefore the number of such candidates times BLK*BLK.
- R4: A candidate is clipped to columns 0..FRM_W-BLK and rows 0..FRM_H-BLK. Every reference read stays inside the clipped window's footprint.
- R5: The score is the sum over the block of |ref - cur| (unsigned pixels), and `min_sad` reports the smallest score found.
- R6: Among equal scores, the first candidate in scan order is kept. Scan order is rows from top to bottom, and within a row columns from left to right.
- R7: `mv_x` = best column - `start_x` and `mv_y` = best row - `start_y`, both two's complement and within ±RANGE.
- R8: `done` is high for exactly one cycle per search. `mv_x`, `mv_y` and `min_sad` change only in a `done` cycle and hold their values until the next one.
- R9: `start` while busy is ignored: the running search completes with its original coordinates. A `start` in the `done` cycle is accepted, because the block is idle then.
- R10: After reset, `busy`, `done`, `cur_rd`, `ref_rd`, `mv_x`, `mv_y` and `min_sad` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| start_x | input | XW | Current block column |
| start_y | input | YW | Current block row |
| busy | output | 1 | Search in progress |
| cur_rd | output | 1 | Current-frame read strobe |
| cur_addr | output | AW | Current-frame read address |
| cur_data | input | PIX_W | Current-frame data, one cycle after the address |
| ref_rd | output | 1 | Reference-frame read strobe |
| ref_addr | output | AW | Reference-frame read address |
| ref_data | input | PIX_W | Reference-frame data, one cycle after the address |
| done | output | 1 | One-cycle result pulse |
| mv_x | output | MVW | Horizontal motion vector (signed) |
| mv_y | output | MVW | Vertical motion vector (signed) |
| min_sad | output | SW | Minimum SAD |

## Verification
The ending of one search and the acceptance of the next can fall in the same cycle. A new `start` is seen while `done` is still high, and the capture of the final result must not disturb the new coordinates. The bench provokes this by driving `start` in the very cycle each table search reports `done`, so every table entry after the first begins back to back with the previous result. Each entry is judged on its own vector, SAD and read counts. A separate case drives `start` in the middle of a search and expects no effect.

// File: rtl/me_pkg.sv
package me_pkg;

    // Control phases of one search
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DRAIN = 2'd3
    } me_state_e;

endpackage

// File: rtl/me_cur_buf.sv
// Register array holding the current block, written once per search.
module me_cur_buf #(
    parameter int NPIX  = 256,
    parameter int PIX_W = 8,
    parameter int IW    = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [PIX_W-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [PIX_W-1:0] rd_data
);

    logic [PIX_W-1:0] pix_q [NPIX];

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        logic [PIX_W-1:0] pix_d;
        always_comb begin
            pix_d = pix_q[g];
            if (wr_en && (wr_idx == IW'(g))) begin
                pix_d = wr_data;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pix_q[g] <= '0;
            else        pix_q[g] <= pix_d;
        end
    end

    assign rd_data = pix_q[rd_idx];

endmodule

// File: rtl/me_sad_acc.sv
// Absolute difference and running sum for one candidate.
module me_sad_acc #(
    parameter int PIX_W = 8,
    parameter int SW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [SW-1:0]    sum
);

    logic [SW-1:0]    acc_d, acc_q;
    logic [PIX_W-1:0] diff;
    logic [SW-1:0]    base;

    always_comb begin
        diff  = (pix_a > pix_b) ? (pix_a - pix_b) : (pix_b - pix_a);
        base  = first ? '0 : acc_q;
        sum   = base + SW'(diff);
        acc_d = en ? sum : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

endmodule

// File: rtl/me_best_track.sv
// Keeps the lowest score and its position; strict compare keeps the earliest.
module me_best_track #(
    parameter int SW = 16,
    parameter int XW = 6,
    parameter int YW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [SW-1:0] cand_sad,
    input  logic [XW-1:0] cand_x,
    input  logic [YW-1:0] cand_y,
    output logic [SW-1:0] nxt_sad,
    output logic [XW-1:0] nxt_x,
    output logic [YW-1:0] nxt_y
);

    typedef struct packed {
        logic          have;
        logic [SW-1:0] sad;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } best_t;

    best_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.have = 1'b0;
        end else if (upd && (!b_q.have || (cand_sad < b_q.sad))) begin
            b_d.have = 1'b1;
            b_d.sad  = cand_sad;
            b_d.x    = cand_x;
            b_d.y    = cand_y;
        end
        nxt_sad = b_d.sad;
        nxt_x   = b_d.x;
        nxt_y   = b_d.y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

endmodule

// File: rtl/me_fullsearch.sv
module me_fullsearch
    import me_pkg::*;
#(
    parameter int BLK   = 16,
    parameter int RANGE = 8,
    parameter int PIX_W = 8,
    parameter int FRM_W = 64,
    parameter int FRM_H = 64,
    parameter int XW    = $clog2(FRM_W),
    parameter int YW    = $clog2(FRM_H),
    parameter int AW    = $clog2(FRM_W * FRM_H),
    parameter int SW    = PIX_W + $clog2(BLK * BLK),
    parameter int MVW   = $clog2(RANGE + 1) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [XW-1:0]         start_x,
    input  logic [YW-1:0]         start_y,
    output logic                  busy,
    output logic                  cur_rd,
    output logic [AW-1:0]         cur_addr,
    input  logic [PIX_W-1:0]      cur_data,
    output logic                  ref_rd,
    output logic [AW-1:0]         ref_addr,
    input  logic [PIX_W-1:0]      ref_data,
    output logic                  done,
    output logic signed [MVW-1:0] mv_x,
    output logic signed [MVW-1:0] mv_y,
    output logic [SW-1:0]         min_sad
);

    localparam int NPIX  = BLK * BLK;
    localparam int NW    = $clog2(NPIX);
    localparam int BW    = $clog2(BLK);
    localparam int MAX_X = FRM_W - BLK;
    localparam int MAX_Y = FRM_H - BLK;

    typedef struct packed {
        me_state_e      st;
        logic [XW-1:0]  x0, lox, hix, cx;
        logic [YW-1:0]  y0, loy, hiy, cy;
        logic [BW-1:0]  px, py;
        logic [NW-1:0]  pidx;
        // read-return stage, aligned with memory data
        logic           pv, pref, plast, pfinal;
        logic [NW-1:0]  pidx_p;
        logic [XW-1:0]  pcx;
        logic [YW-1:0]  pcy;
        // results
        logic           done;
        logic [MVW-1:0] mvx, mvy;
        logic [SW-1:0]  sad;
    } regs_t;

    regs_t r_d, r_q;

    logic             accept;
    logic             last_pix, last_cand, fin;
    logic [BW-1:0]    nxt_px, nxt_py;
    logic [NW-1:0]    nxt_pidx;
    int               lo_x_c, hi_x_c, lo_y_c, hi_y_c;
    int               cur_lin, ref_lin;
    logic [PIX_W-1:0] cur_pix;
    logic [SW-1:0]    sad_sum;
    logic [SW-1:0]    best_sad;
    logic [XW-1:0]    best_x;
    logic [YW-1:0]    best_y;

    // Window bounds, clipped to the frame
    always_comb begin
        lo_x_c = int'(start_x) - RANGE;
        hi_x_c = int'(start_x) + RANGE;
        lo_y_c = int'(start_y) - RANGE;
        hi_y_c = int'(start_y) + RANGE;
        if (lo_x_c < 0)     lo_x_c = 0;
        if (lo_y_c < 0)     lo_y_c = 0;
        if (hi_x_c > MAX_X) hi_x_c = MAX_X;
        if (hi_y_c > MAX_Y) hi_y_c = MAX_Y;
    end

    // Pixel walk inside the block
    always_comb begin
        last_pix  = (r_q.px == BW'(BLK - 1)) && (r_q.py == BW'(BLK - 1));
        last_cand = (r_q.cx == r_q.hix) && (r_q.cy == r_q.hiy);
        if (last_pix) begin
            nxt_px   = '0;
            nxt_py   = '0;
            nxt_pidx = '0;
        end else if (r_q.px == BW'(BLK - 1)) begin
            nxt_px   = '0;
            nxt_py   = r_q.py + BW'(1);
            nxt_pidx = r_q.pidx + NW'(1);
        end else begin
            nxt_px   = r_q.px + BW'(1);
            nxt_py   = r_q.py;
            nxt_pidx = r_q.pidx + NW'(1);
        end
        cur_lin = (int'(r_q.y0) + int'(r_q.py)) * FRM_W + int'(r_q.x0) + int'(r_q.px);
        ref_lin = (int'(r_q.cy) + int'(r_q.py)) * FRM_W + int'(r_q.cx) + int'(r_q.px);
        fin     = r_q.pv && r_q.pref && r_q.plast && r_q.pfinal;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.pv   = 1'b0;
        accept   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    r_d.st   = ST_LOAD;
                    r_d.x0   = start_x;
                    r_d.y0   = start_y;
                    r_d.lox  = XW'(lo_x_c);
                    r_d.hix  = XW'(hi_x_c);
                    r_d.loy  = YW'(lo_y_c);
                    r_d.hiy  = YW'(hi_y_c);
                    r_d.px   = '0;
                    r_d.py   = '0;
                    r_d.pidx = '0;
                end
            end
            ST_LOAD: begin
                r_d.pv     = 1'b1;
                r_d.pref   = 1'b0;
                r_d.pidx_p = r_q.pidx;
                r_d.plast  = last_pix;
                r_d.pfinal = 1'b0;
                r_d.px     = nxt_px;
                r_d.py     = nxt_py;
                r_d.pidx   = nxt_pidx;
                if (last_pix) begin
                    r_d.cx = r_q.lox;
                    r_d.cy = r_q.loy;
                    r_d.st = ST_SCAN;
                end
            end
            ST_SCAN: begin
                r_d.pv     = 1'b1;
                r_d.pref   = 1'b1;
                r_d.pidx_p = r_q.pidx;
                r_d.plast  = last_pix;
                r_d.pfinal = last_cand;
                r_d.pcx    = r_q.cx;
                r_d.pcy    = r_q.cy;
                r_d.px     = nxt_px;
                r_d.py     = nxt_py;
                r_d.pidx   = nxt_pidx;
                if (last_pix) begin
                    if (last_cand) begin
                        r_d.st = ST_DRAIN;
                    end else if (r_q.cx == r_q.hix) begin
                        r_d.cx = r_q.lox;
                        r_d.cy = r_q.cy + YW'(1);
                    end else begin
                        r_d.cx = r_q.cx + XW'(1);
                    end
                end
            end
            ST_DRAIN: begin
                r_d.st = ST_DRAIN;
            end
            default: r_d.st = ST_IDLE;
        endcase
        // Last score of the last candidate arrives: publish the result
        if (fin) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
            r_d.sad  = best_sad;
            r_d.mvx  = MVW'(int'(best_x) - int'(r_q.x0));
            r_d.mvy  = MVW'(int'(best_y) - int'(r_q.y0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    me_cur_buf #(
        .NPIX (NPIX),
        .PIX_W(PIX_W),
        .IW   (NW)
    ) u_cur_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (r_q.pv && !r_q.pref),
        .wr_idx (r_q.pidx_p),
        .wr_data(cur_data),
        .rd_idx (r_q.pidx_p),
        .rd_data(cur_pix)
    );

    me_sad_acc #(
        .PIX_W(PIX_W),
        .SW   (SW)
    ) u_sad (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.pv && r_q.pref),
        .first(r_q.pidx_p == '0),
        .pix_a(ref_data),
        .pix_b(cur_pix),
        .sum  (sad_sum)
    );

    me_best_track #(
        .SW(SW),
        .XW(XW),
        .YW(YW)
    ) u_best (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .upd     (r_q.pv && r_q.pref && r_q.plast),
        .cand_sad(sad_sum),
        .cand_x  (r_q.pcx),
        .cand_y  (r_q.pcy),
        .nxt_sad (best_sad),
        .nxt_x   (best_x),
        .nxt_y   (best_y)
    );

    assign busy     = (r_q.st != ST_IDLE);
    assign cur_rd   = (r_q.st == ST_LOAD);
    assign ref_rd   = (r_q.st == ST_SCAN);
    assign cur_addr = AW'(cur_lin);
    assign ref_addr = AW'(ref_lin);
    assign done     = r_q.done;
    assign mv_x     = r_q.mvx;
    assign mv_y     = r_q.mvy;
    assign min_sad  = r_q.sad;

endmodule

// File: rtl/me_fullsearch_chk.sv
module me_fullsearch_chk #(
    parameter int SW    = 16,
    parameter int MVW   = 5,
    parameter int RANGE = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  cur_rd,
    input logic                  ref_rd,
    input logic signed [MVW-1:0] mv_x,
    input logic signed [MVW-1:0] mv_y,
    input logic [SW-1:0]         min_sad
);

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                      // R1
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                // R1
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cur_rd && !ref_rd));                                 // R1
    AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_rd && ref_rd));                                            // R2
    AST_CUR_BEFORE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_rd) |-> $past(cur_rd));                                // R2
    AST_MV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mv_x >= -RANGE && mv_x <= RANGE && mv_y >= -RANGE && mv_y <= RANGE)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(min_sad) && $stable(mv_x) && $stable(mv_y))); // R8

endmodule

bind me_fullsearch me_fullsearch_chk #(
    .SW   (SW),
    .MVW  (MVW),
    .RANGE(RANGE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .cur_rd (cur_rd),
    .ref_rd (ref_rd),
    .mv_x   (mv_x),
    .mv_y   (mv_y),
    .min_sad(min_sad)
);

// File: tb/me_fullsearch_tb.sv
`timescale 1ns/1ps
module me_fullsearch_tb;

    localparam int BLK = 4, RANGE = 2, FW = 16, FH = 16;
    localparam int NPIX = BLK * BLK;

    // x, y, dx, dy, exp_mvx, exp_mvy, exp_sad, exp_candidates
    localparam int VEC [6][8] = '{
        '{ 6,  6,  1, -2,  1, -2, 0, 25},
        '{ 0,  0,  2,  2,  2,  2, 0,  9},
        '{12, 12, -2,  0, -2,  0, 0,  9},
        '{ 1, 11, -1,  1, -1,  1, 0, 16},
        '{ 8,  3,  0,  0,  0,  0, 0, 25},
        '{ 5,  9, -2,  2, -2,  2, 0, 25}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [3:0]        sx, sy;
    logic              busy, cur_rd, ref_rd, done;
    logic [7:0]        cur_addr, ref_addr;
    logic [7:0]        cur_data, ref_data;
    logic signed [2:0] mv_x, mv_y;
    logic [11:0]       min_sad;

    logic [7:0] cur_mem [256];
    logic [7:0] ref_mem [256];

    int nchk = 0, nerr = 0;
    int cur_cnt = 0, ref_cnt = 0, done_cnt = 0, viol = 0;
    int wlx, whx, wly, why;
    int snap_cur, snap_ref, snap_done;
    int res_mx, res_my, res_sad, res_cur, res_ref;
    logic res_ok, busy_after;

    always #10 clk = ~clk;

    me_fullsearch #(
        .BLK(BLK), .RANGE(RANGE), .PIX_W(8), .FRM_W(FW), .FRM_H(FH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_x(sx), .start_y(sy),
        .busy(busy), .cur_rd(cur_rd), .cur_addr(cur_addr), .cur_data(cur_data),
        .ref_rd(ref_rd), .ref_addr(ref_addr), .ref_data(ref_data),
        .done(done), .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad)
    );

    // Synchronous memories: data one cycle after the address
    always @(posedge clk) begin
        if (cur_rd) cur_data <= cur_mem[cur_addr];
        if (ref_rd) ref_data <= ref_mem[ref_addr];
    end

    // Read and pulse monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (cur_rd) cur_cnt++;
            if (done)   done_cnt++;
            if (ref_rd) begin
                ref_cnt++;
                if ((int'(ref_addr) % FW) < wlx || (int'(ref_addr) % FW) > whx + BLK - 1 ||
                    (int'(ref_addr) / FW) < wly || (int'(ref_addr) / FW) > why + BLK - 1)
                    viol++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hpix(input int x, input int y);
        return 8'((x * x * 3 + y * y * 5 + x * y * 7 + x * 11 + y * 19) * 37 + 5);
    endfunction

    task automatic fill_ref_hash();
        for (int i = 0; i < 256; i++) ref_mem[i] = hpix(i % FW, i / FW);
    endtask

    task automatic fill_ref_const(input int v);
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(v);
    endtask

    task automatic cur_from_ref(input int x, input int y, input int dx, input int dy);
        for (int j = 0; j < BLK; j++)
            for (int i = 0; i < BLK; i++)
                cur_mem[(y + j) * FW + x + i] = hpix(x + dx + i, y + dy + j);
    endtask

    task automatic cur_ramp(input int x, input int y, input int base, input int step);
        for (int j = 0; j < BLK; j++)
            for (int i = 0; i < BLK; i++)
                cur_mem[(y + j) * FW + x + i] = 8'(base + step * (j * BLK + i));
    endtask

    task automatic begin_search(input int x, input int y);
        wlx = (x - RANGE < 0) ? 0 : x - RANGE;
        wly = (y - RANGE < 0) ? 0 : y - RANGE;
        whx = (x + RANGE > FW - BLK) ? FW - BLK : x + RANGE;
        why = (y + RANGE > FH - BLK) ? FH - BLK : y + RANGE;
        snap_cur = cur_cnt;
        snap_ref = ref_cnt;
        start = 1'b1;
        sx = 4'(x);
        sy = 4'(y);
        @(negedge clk);
        start = 1'b0;
        busy_after = busy;
    endtask

    task automatic finish_search();
        res_ok = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done === 1'b1) begin
                res_ok = 1'b1;
                break;
            end
        end
        res_mx  = int'(mv_x);
        res_my  = int'(mv_y);
        res_sad = int'(min_sad);
        res_cur = cur_cnt - snap_cur;
        res_ref = ref_cnt - snap_ref;
        chk("R1 done reached", int'(res_ok), 1);
        chk("R1 busy low in done cycle", int'(busy), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        sx = '0;
        sy = '0;
        wlx = 0; whx = FW; wly = 0; why = FH;
        for (int i = 0; i < 256; i++) cur_mem[i] = '0;
        fill_ref_hash();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 reads", int'(cur_rd) + int'(ref_rd), 0);
        chk("R10 mv", int'(mv_x) * 8 + int'(mv_y), 0);
        chk("R10 sad", int'(min_sad), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk; each start lands in the done cycle of the previous search (R9)
        for (int v = 0; v < 6; v++) begin
            cur_from_ref(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            begin_search(VEC[v][0], VEC[v][1]);
            chk("R1 busy after start", int'(busy_after), 1);
            finish_search();
            chk("R7 mv_x", res_mx, VEC[v][4]);
            chk("R7 mv_y", res_my, VEC[v][5]);
            chk("R5 min_sad", res_sad, VEC[v][6]);
            chk("R2 current reads", res_cur, NPIX);
            chk("R3 reference reads", res_ref, VEC[v][7] * NPIX);
        end
        chk("R4 reads outside clipped window", viol, 0);

        // R6 ties: uniform frames, first candidate of the window wins
        fill_ref_const(100);
        cur_ramp(6, 6, 100, 0);
        begin_search(6, 6);
        finish_search();
        chk("R6 tie mv_x", res_mx, -2);
        chk("R6 tie mv_y", res_my, -2);
        cur_ramp(0, 5, 100, 0);
        begin_search(0, 5);
        finish_search();
        chk("R6 clipped tie mv_x", res_mx, 0);
        chk("R6 clipped tie mv_y", res_my, -2);

        // R5 metric: constant offset, and differences of both signs
        fill_ref_const(10);
        cur_ramp(6, 6, 13, 0);
        begin_search(6, 6);
        finish_search();
        chk("R5 offset sad", res_sad, 48);
        fill_ref_const(20);
        cur_ramp(6, 6, 10, 1);
        begin_search(6, 6);
        finish_search();
        chk("R5 mixed sign sad", res_sad, 70);
        chk("R6 equal scores mv_x", res_mx, -2);

        // R9: start in mid-search is ignored
        repeat (3) @(negedge clk);
        fill_ref_hash();
        cur_from_ref(6, 6, 1, -2);
        snap_done = done_cnt;
        begin_search(6, 6);
        repeat (30) @(negedge clk);
        start = 1'b1;
        sx = 4'd0;
        sy = 4'd0;
        @(negedge clk);
        start = 1'b0;
        finish_search();
        chk("R9 mv_x kept", res_mx, 1);
        chk("R9 mv_y kept", res_my, -2);
        chk("R9 current reads", res_cur, NPIX);
        chk("R9 reference reads", res_ref, 25 * NPIX);

        // R8: single pulse and held results
        @(negedge clk);
        chk("R8 done drops", int'(done), 0);
        repeat (10) @(negedge clk);
        chk("R8 done count", done_cnt - snap_done, 1);
        chk("R8 mv_x held", int'(mv_x), res_mx);
        chk("R8 mv_y held", int'(mv_y), res_my);
        chk("R8 sad held", int'(min_sad), res_sad);
        chk("R1 idle busy", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule